// File: doc/BRIEF.md
# Packed Quotient-Remainder Divider

This block is a sequential integer divider that serves a processor execution unit. It has two operand sizes. In byte mode it divides a 16-bit dividend by an 8-bit divisor. In word mode it divides a 32-bit dividend by a 16-bit divisor. Either size can run unsigned or signed.

The quotient and the remainder come back packed into one register-width word. The remainder sits in the upper half and the low part of the quotient in the lower half. This lets the caller write both to a single destination register.

Operation is a pulse-started, fixed-latency job:
- The caller raises `start` for one cycle with the operands and the mode.
- The block works through one quotient bit per clock on operand magnitudes. It corrects the signs at the end.
- It then presents the packed result together with a negative flag and a zero flag, and pulses `done`.

A zero divisor produces no quotient. The output word keeps its old value, and the zero flag reports the event.

Top module: `packed_divider`

## Requirements
- R1: While reset is held and after it is released, before any start, `busy`, `done`, `n_flag` and `z_flag` are 0 and `result` is 0.
- R2: With `mode_word`=0 (byte mode) only `dividend[15:0]` and `divisor[7:0]` are used; the bits above them are ignored. The result layout is `result[7:0]` = low 8 bits of the quotient, `result[15:8]` = remainder, and `result[31:16]` = 0. With `is_signed`=0 the operands are unsigned, and quotient bits above bit 7 are dropped.
- R3: With `mode_word`=1 (word mode) the result layout is `result[15:0]` = low 16 bits of the quotient and `result[31:16]` = remainder. With `is_signed`=0 both operands are unsigned.
- R4: In byte mode with `is_signed`=1, both the 16-bit dividend and the 8-bit divisor are taken as two's complement. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.
- R5: In word mode with `is_signed`=1, the 32-bit dividend is used as a two's complement value and the 16-bit divisor is sign-extended. Truncation and remainder sign follow R4.
- R6: After a nonzero divisor, `n_flag` equals the quotient's sign bit at operand width (`result[7]` in byte mode, `result[15]` in word mode) and `z_flag` is 0. Both flags change only when `done` is high.
- R7: A divisor that is zero at operand width (only `divisor[7:0]` counts in byte mode) leaves `result` unchanged and sets `z_flag`=1 and `n_flag`=0. `done` still pulses.
- R8: `done` is high in the cycle that follows a fixed number of clock edges after the edge that accepts `start`: 17 edges in byte mode, 33 in word mode, and 1 for a zero divisor.
- R9: `busy` is high from the cycle after an accepted start up to, but not including, the `done` cycle. `done` lasts exactly one cycle and is never high together with `busy`. A start in the `done` cycle is accepted.
- R10: A start pulse while `busy` is high is ignored. It produces no extra `done` and does not alter `result` or the flags of the job in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| mode_word | input | 1 | 0 = byte mode (16/8), 1 = word mode (32/16) |
| is_signed | input | 1 | 1 = two's complement operands |
| dividend | input | 32 | Dividend; byte mode uses bits 15:0 |
| divisor | input | 16 | Divisor; byte mode uses bits 7:0 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed remainder (upper half) and quotient (lower half) |
| n_flag | output | 1 | Sign of the quotient at operand width |
| z_flag | output | 1 | Divisor was zero |

## Verification
Two of the block's functions can meet in a single cycle: completion of one job (the `done` pulse and the result write) and the arrival of a new start.

The bench provokes both orderings of this collision:
- It raises `start` in the exact cycle `done` is high. That start must be accepted, and its own packed result must follow with the full latency.
- It raises `start` in the last busy cycle, one cycle before `done`. That start must vanish, with no second `done` and an unchanged `result`.

A scoreboard queue holds one expected item per accepted start. Any `done` without a pending item counts as a failure.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Sequencer state of the divider.
    typedef enum logic {
        PD_IDLE = 1'b0,
        PD_RUN  = 1'b1
    } pdiv_state_e;

    // Default word-mode divisor width; byte mode uses half of it.
    localparam int PDIV_DEF_DW = 16;

endpackage

// File: rtl/pdiv_operand_prep.sv
// Turns raw operands into magnitudes and sign decisions.
// In byte mode the dividend magnitude is left-aligned in the
// shift register so that fewer iterations finish the job.
module pdiv_operand_prep #(
    parameter int DW = 16
) (
    input  logic              wide,
    input  logic              sgn,
    input  logic [2*DW-1:0]   dividend,
    input  logic [DW-1:0]     divisor,
    output logic [2*DW-1:0]   dvd_mag,
    output logic [DW-1:0]     dvs_mag,
    output logic              q_neg,
    output logic              r_neg,
    output logic              dvs_zero
);
    localparam int BW = DW / 2;
    localparam int XW = 2 * DW;

    logic          dvd_neg_b;
    logic          dvd_neg_w;
    logic          dvs_neg_b;
    logic          dvs_neg_w;
    logic [DW-1:0] dvd_lo;
    logic [DW-1:0] dvd_lo_mag;
    logic [XW-1:0] dvd_full_mag;
    logic [BW-1:0] dvs_lo;
    logic [BW-1:0] dvs_lo_mag;
    logic [DW-1:0] dvs_full_mag;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        dvd_lo       = dividend[DW-1:0];
        dvs_lo       = divisor[BW-1:0];

        dvd_neg_b    = sgn & dvd_lo[DW-1];
        dvd_neg_w    = sgn & dividend[XW-1];
        dvs_neg_b    = sgn & dvs_lo[BW-1];
        dvs_neg_w    = sgn & divisor[DW-1];

        dvd_lo_mag   = dvd_neg_b ? (~dvd_lo + 1'b1) : dvd_lo;
        dvd_full_mag = dvd_neg_w ? (~dividend + 1'b1) : dividend;
        dvs_lo_mag   = dvs_neg_b ? (~dvs_lo + 1'b1) : dvs_lo;
        dvs_full_mag = dvs_neg_w ? (~divisor + 1'b1) : divisor;

        if (wide) begin
            dvd_mag  = dvd_full_mag;
            dvs_mag  = dvs_full_mag;
            dvd_neg  = dvd_neg_w;
            dvs_neg  = dvs_neg_w;
            dvs_zero = (divisor == '0);
        end else begin
            dvd_mag  = {dvd_lo_mag, {DW{1'b0}}};
            dvs_mag  = {{(DW-BW){1'b0}}, dvs_lo_mag};
            dvd_neg  = dvd_neg_b;
            dvs_neg  = dvs_neg_b;
            dvs_zero = (dvs_lo == '0);
        end

        q_neg = dvd_neg ^ dvs_neg;
        r_neg = dvd_neg;
    end

endmodule

// File: rtl/pdiv_restore_step.sv
// One restoring-division iteration: shift in the next dividend bit,
// trial-subtract the divisor, keep the difference when it fits.
module pdiv_restore_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   rem_in,
    input  logic [2*DW-1:0] quo_in,
    input  logic [DW-1:0]   dvs,
    output logic [DW-1:0]   rem_out,
    output logic [2*DW-1:0] quo_out
);
    localparam int XW = 2 * DW;

    logic [DW:0] trial;
    logic        fits;

    always_comb begin
        trial   = {rem_in, quo_in[XW-1]};
        fits    = (trial >= {1'b0, dvs});
        rem_out = fits ? DW'(trial - {1'b0, dvs}) : trial[DW-1:0];
        quo_out = {quo_in[XW-2:0], fits};
    end

endmodule

// File: rtl/pdiv_result_pack.sv
// Applies the final signs and places remainder above quotient.
module pdiv_result_pack #(
    parameter int DW = 16
) (
    input  logic              wide,
    input  logic              q_neg,
    input  logic              r_neg,
    input  logic [DW-1:0]     quo_lo,
    input  logic [DW-1:0]     rem,
    output logic [2*DW-1:0]   packed_res,
    output logic              neg_flag
);
    localparam int BW = DW / 2;

    logic [DW-1:0] q_mag;
    logic [DW-1:0] q_fix;
    logic [DW-1:0] r_fix;

    always_comb begin
        q_mag = wide ? quo_lo : {{(DW-BW){1'b0}}, quo_lo[BW-1:0]};
        q_fix = q_neg ? (~q_mag + 1'b1) : q_mag;
        r_fix = r_neg ? (~rem + 1'b1) : rem;

        if (wide) begin
            packed_res = {r_fix, q_fix};
            neg_flag   = q_fix[DW-1];
        end else begin
            packed_res = {{DW{1'b0}}, r_fix[BW-1:0], q_fix[BW-1:0]};
            neg_flag   = q_fix[BW-1];
        end
    end

endmodule

// File: rtl/packed_divider.sv
// Sequential divider with packed remainder/quotient output.
module packed_divider
    import pdiv_pkg::*;
#(
    parameter int DW = PDIV_DEF_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_word,
    input  logic              is_signed,
    input  logic [2*DW-1:0]   dividend,
    input  logic [DW-1:0]     divisor,
    output logic              busy,
    output logic              done,
    output logic [2*DW-1:0]   result,
    output logic              n_flag,
    output logic              z_flag
);
    localparam int XW = 2 * DW;
    localparam int CW = $clog2(XW + 1);
    localparam logic [CW-1:0] ITER_BYTE = CW'(DW);
    localparam logic [CW-1:0] ITER_WORD = CW'(XW);

    typedef struct packed {
        pdiv_state_e   state;
        logic          wide;
        logic          q_neg;
        logic          r_neg;
        logic          dz;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dvs;
        logic [DW-1:0] rem;
        logic [XW-1:0] quo;
        logic [XW-1:0] res;
        logic          n;
        logic          z;
        logic          done;
    } pdiv_regs_t;

    pdiv_regs_t cur_q;
    pdiv_regs_t nxt_d;

    // Operand preparation (combinational, used at launch).
    logic [XW-1:0] prep_dvd_d;
    logic [DW-1:0] prep_dvs_d;
    logic          prep_qneg_d;
    logic          prep_rneg_d;
    logic          prep_zero_d;

    pdiv_operand_prep #(.DW(DW)) u_prep (
        .wide     (mode_word),
        .sgn      (is_signed),
        .dividend (dividend),
        .divisor  (divisor),
        .dvd_mag  (prep_dvd_d),
        .dvs_mag  (prep_dvs_d),
        .q_neg    (prep_qneg_d),
        .r_neg    (prep_rneg_d),
        .dvs_zero (prep_zero_d)
    );

    // One iteration of the magnitude divider.
    logic [DW-1:0] step_rem_d;
    logic [XW-1:0] step_quo_d;

    pdiv_restore_step #(.DW(DW)) u_step (
        .rem_in  (cur_q.rem),
        .quo_in  (cur_q.quo),
        .dvs     (cur_q.dvs),
        .rem_out (step_rem_d),
        .quo_out (step_quo_d)
    );

    // Sign fix-up and packing of the finished magnitudes.
    logic [XW-1:0] pack_res_d;
    logic          pack_neg_d;

    pdiv_result_pack #(.DW(DW)) u_pack (
        .wide       (cur_q.wide),
        .q_neg      (cur_q.q_neg),
        .r_neg      (cur_q.r_neg),
        .quo_lo     (cur_q.quo[DW-1:0]),
        .rem        (cur_q.rem),
        .packed_res (pack_res_d),
        .neg_flag   (pack_neg_d)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;

        case (cur_q.state)
            PD_IDLE: begin
                if (start) begin
                    nxt_d.state = PD_RUN;
                    nxt_d.wide  = mode_word;
                    nxt_d.q_neg = prep_qneg_d;
                    nxt_d.r_neg = prep_rneg_d;
                    nxt_d.dz    = prep_zero_d;
                    nxt_d.dvs   = prep_dvs_d;
                    nxt_d.rem   = '0;
                    nxt_d.quo   = prep_dvd_d;
                    if (prep_zero_d) begin
                        nxt_d.cnt = '0;
                    end else if (mode_word) begin
                        nxt_d.cnt = ITER_WORD;
                    end else begin
                        nxt_d.cnt = ITER_BYTE;
                    end
                end
            end

            PD_RUN: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.state = PD_IDLE;
                    nxt_d.done  = 1'b1;
                    if (cur_q.dz) begin
                        nxt_d.z = 1'b1;
                        nxt_d.n = 1'b0;
                    end else begin
                        nxt_d.res = pack_res_d;
                        nxt_d.n   = pack_neg_d;
                        nxt_d.z   = 1'b0;
                    end
                end else begin
                    nxt_d.rem = step_rem_d;
                    nxt_d.quo = step_quo_d;
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            default: begin
                nxt_d.state = PD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = (cur_q.state == PD_RUN);
    assign done   = cur_q.done;
    assign result = cur_q.res;
    assign n_flag = cur_q.n;
    assign z_flag = cur_q.z;

endmodule

// File: rtl/pdiv_checker.sv
// Temporal properties of the divider, attached by bind.
module pdiv_checker #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [2*DW-1:0] result,
    input logic            n_flag,
    input logic            z_flag
);
    localparam int CW = $clog2(2 * DW + 2);

    logic [CW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (busy) begin
            run_len_q <= run_len_q + 1'b1;
        end else begin
            run_len_q <= '0;
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len_q == CW'(1) || run_len_q == CW'(DW + 1)
                  || run_len_q == CW'(2 * DW + 1)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(n_flag) && $stable(z_flag)));

    // R7
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && z_flag) |-> (result == $past(result) && !n_flag));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_flag |-> !n_flag);

endmodule

bind packed_divider pdiv_checker #(.DW(DW)) u_pdiv_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .n_flag (n_flag),
    .z_flag (z_flag)
);

// File: tb/tb_packed_divider.sv
`timescale 1ns/1ps
module tb_packed_divider;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        mode_word;
    logic        is_signed;
    logic [31:0] dividend;
    logic [15:0] divisor;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        n_flag;
    logic        z_flag;

    always #10 clk = ~clk;

    packed_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_word (mode_word),
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .n_flag    (n_flag),
        .z_flag    (z_flag)
    );

    typedef struct {
        logic [31:0] res;
        logic        n;
        logic        z;
        longint      due;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    longint      cyc = 0;
    logic [31:0] model_res = 32'h0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input bit w, input bit s, input logic [31:0] a_in,
                         input logic [15:0] b_in, output exp_t e, output int lat);
        longint a, b, qq, rr;
        if (w) begin
            a = s ? longint'($signed(a_in)) : longint'({32'b0, a_in});
            b = s ? longint'($signed(b_in)) : longint'({48'b0, b_in});
        end else begin
            a = s ? longint'($signed(a_in[15:0])) : longint'({48'b0, a_in[15:0]});
            b = s ? longint'($signed(b_in[7:0]))  : longint'({56'b0, b_in[7:0]});
        end
        if (b == 0) begin
            e.res = model_res; e.n = 1'b0; e.z = 1'b1; lat = 1;
        end else begin
            qq = a / b;
            rr = a % b;
            if (w) begin
                e.res = {rr[15:0], qq[15:0]}; e.n = qq[15]; lat = 33;
            end else begin
                e.res = {16'h0, rr[7:0], qq[7:0]}; e.n = qq[7]; lat = 17;
            end
            e.z = 1'b0;
            model_res = e.res;
        end
    endtask

    // Driver: called at a falling edge; returns the due cycle.
    task automatic issue(input bit w, input bit s, input logic [31:0] a,
                         input logic [15:0] b, input string tag, output longint due);
        exp_t e;
        int   lat;
        model(w, s, a, b, e, lat);
        e.due = cyc + 1 + lat;
        e.tag = tag;
        due   = e.due;
        sb_q.push_back(e);
        mode_word = w; is_signed = s; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R9 busy after start ", tag}, 64'(busy), 64'd1);
    endtask

    task automatic drain();
        while (sb_q.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (busy && done) chk(1'b0, "R9 busy with done", 64'd1, 64'd0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10 done without accepted start", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(result == e.res, {"result ", e.tag}, 64'(result), 64'(e.res));
                    chk(n_flag == e.n, {"R6 n_flag ", e.tag}, 64'(n_flag), 64'(e.n));
                    chk(z_flag == e.z, {"R7 z_flag ", e.tag}, 64'(z_flag), 64'(e.z));
                    chk(cyc == e.due, {"R8 latency ", e.tag}, 64'(cyc), 64'(e.due));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint due;
        rst_n = 1'b0; start = 1'b0; mode_word = 1'b0; is_signed = 1'b0;
        dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && result == 0 && !n_flag && !z_flag, "R1 in reset",
            {result, 28'h0, busy, done, n_flag, z_flag}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && result == 0 && !n_flag && !z_flag, "R1 after release",
            {result, 28'h0, busy, done, n_flag, z_flag}, 64'h0);

        // R2 unsigned byte, upper operand bits must be ignored
        issue(1'b0, 1'b0, 32'hDEAD_03E8, 16'hA507, "R2 ubyte 1000/7", due); drain();
        issue(1'b0, 1'b0, 32'h0000_FFFF, 16'h0001, "R2 ubyte quotient overflow", due); drain();
        issue(1'b0, 1'b0, 32'h0000_00FE, 16'h00FF, "R2 ubyte small", due); drain();
        // R3 unsigned word
        issue(1'b1, 1'b0, 32'h1234_5678, 16'h1234, "R3 uword", due); drain();
        issue(1'b1, 1'b0, 32'hFFFF_FFFF, 16'hFFFF, "R3 uword max", due); drain();
        // R4 signed byte
        issue(1'b0, 1'b1, 32'h0000_FF9C, 16'h0007, "R4 sbyte -100/7", due); drain();
        issue(1'b0, 1'b1, 32'h0000_0064, 16'h00F9, "R4 sbyte 100/-7", due); drain();
        issue(1'b0, 1'b1, 32'h0000_8000, 16'h0080, "R4 sbyte min/min", due); drain();
        issue(1'b0, 1'b1, 32'h0000_FF9C, 16'h00F9, "R4 sbyte -100/-7", due); drain();
        // R5 signed word
        issue(1'b1, 1'b1, 32'hFFF0_BDC0, 16'h012C, "R5 sword -1000000/300", due); drain();
        issue(1'b1, 1'b1, 32'h8000_0000, 16'hFFFF, "R5 sword min/-1", due); drain();
        issue(1'b1, 1'b1, 32'h0001_0000, 16'h8000, "R5 sword 65536/-32768", due); drain();
        // R7 zero divisor at operand width
        issue(1'b0, 1'b1, 32'h0000_1234, 16'h0300, "R7 byte zero divisor", due); drain();
        issue(1'b1, 1'b0, 32'h0000_1234, 16'h0000, "R7 word zero divisor", due); drain();

        // R9 start in the done cycle is accepted
        issue(1'b0, 1'b0, 32'h0000_3039, 16'h000D, "R9 first of pair", due);
        do @(negedge clk); while (!done);
        issue(1'b1, 1'b1, 32'hFEDC_BA98, 16'h0123, "R9 start on done cycle", due);
        drain();

        // R10 start while busy (mid-run and last busy cycle) is ignored
        issue(1'b1, 1'b0, 32'h0BAD_F00D, 16'h0777, "R10 job with mid-run poke", due);
        repeat (5) @(negedge clk);
        mode_word = 1'b0; dividend = 32'h0000_0010; divisor = 16'h0002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        issue(1'b1, 1'b1, 32'h7654_3210, 16'hF00F, "R10 job with late poke", due);
        while (cyc != due - 1) @(negedge clk);
        mode_word = 1'b0; dividend = 32'h0000_0009; divisor = 16'h0003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(!busy && sb_q.size() == 0, "R10 no relaunch after ignored start",
            64'(busy), 64'd0);

        // Mixed patterns covering R2 R3 R4 R5 R6
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a;
            logic [15:0] b;
            a = $urandom;
            b = 16'($urandom);
            issue(1'(i % 2), 1'((i / 2) % 2), a, b, "R6 mixed pattern", due);
            drain();
        end

        chk(sb_q.size() == 0, "R10 scoreboard empty at end", 64'(sb_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule